// File: doc/BRIEF.md
# Packed SIMD Integer Arithmetic Unit

This unit performs integer arithmetic on two wide operands that it splits into independent lanes. Each issue selects the lane width at run time: 8, 16 or 32 bits. Each issue also selects signed or unsigned interpretation, saturating or wraparound arithmetic, and one of five operations: add, subtract, minimum, maximum and rounded average. Every lane is computed on its own. Its result is placed at the same bit position as its inputs, and no carry or borrow ever crosses a lane boundary.

An operation is issued by raising `in_valid` for one cycle with operands and controls applied. The packed result is registered and appears one clock later with `out_valid` high for that one cycle. The result register keeps its value until the next issue. A sticky status bit records that some lane of some saturating add or subtract was clamped. It stays set until the surrounding logic pulses `sat_clr`.

Top module: `psau_top`

## Requirements
- R1: `elem_sz` selects the lane width: 0 gives 8 bits (16 lanes), 1 gives 16 bits (8 lanes), and 2 or 3 give 32 bits (4 lanes). No carry or borrow passes from one lane into the next.
- R2: With `sat_mode`=0, add (`opcode`=0) and subtract (`opcode`=1) return the low lane-width bits of the exact result (wraparound).
- R3: With `sat_mode`=1 and `is_signed`=1, an add or subtract whose exact result leaves the signed lane range returns the most positive value (0x7F..) or the most negative value (0x80..) of the lane.
- R4: With `sat_mode`=1 and `is_signed`=0, an add or subtract above the lane range returns all ones, and one below zero returns zero.
- R5: Minimum (`opcode`=2) and maximum (`opcode`=3) return the smaller or larger lane operand, compared as signed or unsigned according to `is_signed`. They never saturate.
- R6: Average (`opcode`=4) returns floor((a+b+1)/2), computed at lane width plus two bits, so it never overflows and never saturates.
- R7: Opcodes 5, 6 and 7 return an all-zero result and never set the saturation status.
- R8: The `result` value and `out_valid` become valid on the first rising clock edge after `in_valid` is sampled high. `out_valid` is high for exactly one cycle per issue.
- R9: While `in_valid` is low, `result` keeps its last value whatever the operand and control inputs do.
- R10: `sat_flag` becomes 1 on the edge that captures an issue in which any lane was clamped, and stays 1 after that.
- R11: `sat_flag` is cleared only by `sat_clr`. A clamp that occurs in the same cycle as `sat_clr` wins, and the flag stays set.
- R12: Asynchronous active-low reset clears `result`, `out_valid` and `sat_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Issue strobe |
| opnd_a | input | 128 | First packed operand |
| opnd_b | input | 128 | Second packed operand |
| elem_sz | input | 2 | Lane width select |
| is_signed | input | 1 | 1 selects signed lane interpretation |
| sat_mode | input | 1 | 1 selects saturating add/subtract |
| opcode | input | 3 | Operation select |
| sat_clr | input | 1 | Clears the sticky saturation flag |
| out_valid | output | 1 | Result valid, one cycle per issue |
| result | output | 128 | Packed registered result |
| sat_flag | output | 1 | Sticky saturation status |

## Verification
Every result, `out_valid` and any change of `sat_flag` caused by an issue is due on the single rising edge after the issue cycle. No other latency exists. The bench applies each issue just after a falling edge, lets the next rising edge capture it, and samples all outputs at the following falling edge, a full half-period away from any active edge. For the hold and clear-only checks, the bench samples one and two falling edges after the stimulus, when `out_valid` must already be back at zero.

// File: rtl/psau_pkg.sv
package psau_pkg;
   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_SUB = 3'd1,
      OP_MIN = 3'd2,
      OP_MAX = 3'd3,
      OP_AVG = 3'd4
   } psau_op_e;

   typedef enum logic [1:0] {
      SZ_8   = 2'd0,
      SZ_16  = 2'd1,
      SZ_32  = 2'd2,
      SZ_32X = 2'd3
   } psau_sz_e;

   localparam int NUM_SIZES = 3;
   localparam int BASE_LW   = 8;
endpackage

// File: rtl/psau_lane.sv
module psau_lane
   import psau_pkg::*;
#(
   parameter int LW = 8
) (
   input  logic [LW-1:0] a,
   input  logic [LW-1:0] b,
   input  logic [2:0]    op,
   input  logic          sgn,
   input  logic          sat_en,
   output logic [LW-1:0] res,
   output logic          clamp
);
   localparam int XW = LW + 2;

   if (LW < 2) begin : g_bad_lw
      $error("psau_lane: LW must be at least 2");
   end

   logic signed [XW-1:0] ext_a, ext_b, sum, dif, full, rnd;
   logic signed [XW-1:0] hi_lim, lo_lim;
   logic                 lt, over, under, arith;

   always_comb begin
      ext_a  = $signed({{2{sgn & a[LW-1]}}, a});
      ext_b  = $signed({{2{sgn & b[LW-1]}}, b});
      sum    = ext_a + ext_b;
      dif    = ext_a - ext_b;
      rnd    = sum + XW'(1);
      lt     = dif[XW-1];
      hi_lim = sgn ? $signed({3'b000, {(LW-1){1'b1}}}) : $signed({2'b00, {LW{1'b1}}});
      lo_lim = sgn ? $signed({3'b111, {(LW-1){1'b0}}}) : '0;
      full   = (op == OP_SUB) ? dif : sum;
      arith  = (op == OP_ADD) || (op == OP_SUB);
      over   = full > hi_lim;
      under  = full < lo_lim;
      clamp  = arith && sat_en && (over || under);
      unique case (op)
         OP_ADD, OP_SUB: begin
            if (sat_en && over)       res = hi_lim[LW-1:0];
            else if (sat_en && under) res = lo_lim[LW-1:0];
            else                      res = full[LW-1:0];
         end
         OP_MIN:  res = lt ? a : b;
         OP_MAX:  res = lt ? b : a;
         OP_AVG:  res = rnd[LW:1];
         default: res = '0;
      endcase
   end

   logic signed [XW-1:0] ext_r;
   assign ext_r = $signed({{2{sgn & res[LW-1]}}, res});

   always_comb begin
      if (op == OP_MIN || op == OP_MAX)
         AST_MINMAX_PICKS_OPERAND: assert (res == a || res == b);                      // R5
      if (op == OP_AVG)
         AST_AVG_WITHIN_OPERANDS: assert ((ext_r >= ext_a || ext_r >= ext_b) &&
                                          (ext_r <= ext_a || ext_r <= ext_b));         // R6
      if (op > OP_AVG)
         AST_UNUSED_OP_ZERO: assert (res == '0 && !clamp);                             // R7
   end
endmodule

// File: rtl/psau_group.sv
module psau_group
   import psau_pkg::*;
#(
   parameter int DW = 128,
   parameter int LW = 8
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic [2:0]    op,
   input  logic          sgn,
   input  logic          sat_en,
   output logic [DW-1:0] res,
   output logic          clamp_any
);
   localparam int NL = DW / LW;

   if (DW % LW != 0) begin : g_bad_split
      $error("psau_group: DW must be a multiple of LW");
   end

   logic [NL-1:0] clamp_v;

   for (genvar i = 0; i < NL; i++) begin : g_lane
      psau_lane #(.LW(LW)) i_lane (
         .a      (a[i*LW +: LW]),
         .b      (b[i*LW +: LW]),
         .op     (op),
         .sgn    (sgn),
         .sat_en (sat_en),
         .res    (res[i*LW +: LW]),
         .clamp  (clamp_v[i])
      );
   end

   assign clamp_any = |clamp_v;
endmodule

// File: rtl/psau_top.sv
module psau_top
   import psau_pkg::*;
#(
   parameter int DATA_W = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [1:0]        elem_sz,
   input  logic              is_signed,
   input  logic              sat_mode,
   input  logic [2:0]        opcode,
   input  logic              sat_clr,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              sat_flag
);
   localparam int MAX_LW = BASE_LW << (NUM_SIZES - 1);

   if (DATA_W < MAX_LW || DATA_W % MAX_LW != 0) begin : g_bad_width
      $error("psau_top: DATA_W must be a positive multiple of the widest lane");
   end

   logic [DATA_W-1:0] grp_res   [NUM_SIZES];
   logic              grp_clamp [NUM_SIZES];

   for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
      psau_group #(.DW(DATA_W), .LW(BASE_LW << g)) i_group (
         .a         (opnd_a),
         .b         (opnd_b),
         .op        (opcode),
         .sgn       (is_signed),
         .sat_en    (sat_mode),
         .res       (grp_res[g]),
         .clamp_any (grp_clamp[g])
      );
   end

   logic [1:0]        sz_idx;
   logic [DATA_W-1:0] sel_res;
   logic              sel_clamp;

   always_comb begin
      unique case (psau_sz_e'(elem_sz))
         SZ_8:    sz_idx = 2'd0;
         SZ_16:   sz_idx = 2'd1;
         default: sz_idx = 2'd2;
      endcase
      sel_res   = grp_res[sz_idx];
      sel_clamp = grp_clamp[sz_idx];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         sat_flag  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= sel_res;
         if (in_valid && sel_clamp) sat_flag <= 1'b1;
         else if (sat_clr)          sat_flag <= 1'b0;
      end
   end

   AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));                                                   // R9
   AST_STICKY_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sat_flag) |-> $past(in_valid) && $past(sat_mode) && ($past(opcode) < 3'd2)); // R10
   AST_STICKY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      sat_flag && !sat_clr |=> sat_flag);                                               // R11
   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);                                                          // R8
   AST_NO_SAT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !sat_mode && !sat_flag && !sat_clr |=> !sat_flag);                    // R2
endmodule

// File: tb/test_psau_top.sv
module test_psau_top;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [127:0] opnd_a = '0, opnd_b = '0;
   logic [1:0]   elem_sz = '0;
   logic         is_signed = 1'b0, sat_mode = 1'b0, sat_clr = 1'b0;
   logic [2:0]   opcode = '0;
   logic         out_valid, sat_flag;
   logic [127:0] result;

   int n_chk = 0, n_bad = 0;
   logic exp_flag = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   psau_top #(.DATA_W(128)) i_psau_top (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .elem_sz(elem_sz), .is_signed(is_signed), .sat_mode(sat_mode), .opcode(opcode),
      .sat_clr(sat_clr), .out_valid(out_valid), .result(result), .sat_flag(sat_flag)
   );

   task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                          input logic [1:0] es, input logic sg, input logic st,
                                          input logic [2:0] op, output logic cl);
      int w = (es == 2'd3) ? 32 : (8 << es);
      longint m = (longint'(1) << w) - 1;
      longint hi = sg ? (longint'(1) << (w-1)) - 1 : m;
      longint lo = sg ? -(longint'(1) << (w-1)) : 0;
      logic [127:0] r_all = '0;
      cl = 1'b0;
      for (int i = 0; i < 128 / w; i++) begin
         longint x = longint'(a >> (i*w)) & m;
         longint y = longint'(b >> (i*w)) & m;
         longint r;
         if (sg && x[w-1]) x = x - (m + 1);
         if (sg && y[w-1]) y = y - (m + 1);
         case (op)
            3'd0:    r = x + y;
            3'd1:    r = x - y;
            3'd2:    r = (x < y) ? x : y;
            3'd3:    r = (x > y) ? x : y;
            3'd4:    r = (x + y + 1) >>> 1;
            default: r = 0;
         endcase
         if (op <= 3'd1 && st) begin
            if (r > hi)      begin r = hi; cl = 1'b1; end
            else if (r < lo) begin r = lo; cl = 1'b1; end
         end
         r_all = r_all | (128'(r & m) << (i*w));
      end
      return r_all;
   endfunction

   task automatic issue(string req, logic [127:0] a, logic [127:0] b, logic [1:0] es,
                        logic sg, logic st, logic [2:0] op, logic clr);
      logic [127:0] exp;
      logic cl;
      @(negedge clk);
      opnd_a = a; opnd_b = b; elem_sz = es; is_signed = sg; sat_mode = st;
      opcode = op; sat_clr = clr; in_valid = 1'b1;
      exp = model(a, b, es, sg, st, op, cl);
      if (cl) exp_flag = 1'b1;
      else if (clr) exp_flag = 1'b0;
      @(negedge clk);
      in_valid = 1'b0; sat_clr = 1'b0;
      chk({req, " result"}, result, exp);
      chk("R8 out_valid", 128'(out_valid), 128'(1));
      chk({req, " sat_flag"}, 128'(sat_flag), 128'(exp_flag));
   endtask

   task automatic t_reset;
      chk("R12 result", result, '0);
      chk("R12 out_valid", 128'(out_valid), '0);
      chk("R12 sat_flag", 128'(sat_flag), '0);
   endtask

   task automatic t_modulo;
      issue("R1_R2 8b wrap", {16{8'hFF}}, {16{8'h01}}, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0);
      chk("R1 no carry 8b", result, '0);
      issue("R1_R2 16b wrap", {16{8'hFF}}, {16{8'h01}}, 2'd1, 1'b0, 1'b0, 3'd0, 1'b0);
      issue("R1_R2 32b sub", 128'h00000000_80000000_12345678_FFFFFFFF,
            128'h00000001_00000001_87654321_FFFFFFFF, 2'd2, 1'b1, 1'b0, 3'd1, 1'b0);
      issue("R1 size3 as 32", 128'h7FFFFFFF_0000FFFF_FFFFFFFF_01020304,
            128'h00000001_00000001_00000001_F0F0F0F0, 2'd3, 1'b0, 1'b0, 3'd0, 1'b0);
      @(negedge clk);
      chk("R8 out_valid drops", 128'(out_valid), '0);
   endtask

   task automatic t_signed_sat;
      issue("R3 add hi", {8{8'h7F, 8'h80}}, {8{8'h01, 8'hFF}}, 2'd0, 1'b1, 1'b1, 3'd0, 1'b0);
      chk("R3 add hi clamp", result, {8{8'h7F, 8'h80}});
      chk("R10 set", 128'(sat_flag), 128'(1));
      issue("R3 sub 16", {8{16'h8000}}, {8{16'h0001}}, 2'd1, 1'b1, 1'b1, 3'd1, 1'b0);
      issue("R3 no clamp", {4{32'h00000010}}, {4{32'h00000020}}, 2'd2, 1'b1, 1'b1, 3'd1, 1'b0);
   endtask

   task automatic t_clear;
      @(negedge clk); sat_clr = 1'b1;
      @(negedge clk); sat_clr = 1'b0;
      chk("R11 clear", 128'(sat_flag), '0);
      exp_flag = 1'b0;
      issue("R11 set beats clear", {16{8'hF0}}, {16{8'h20}}, 2'd0, 1'b0, 1'b1, 3'd0, 1'b1);
      chk("R11 flag kept", 128'(sat_flag), 128'(1));
      issue("R11 clear on issue", {16{8'h01}}, {16{8'h01}}, 2'd0, 1'b0, 1'b1, 3'd0, 1'b1);
      chk("R11 cleared", 128'(sat_flag), '0);
   endtask

   task automatic t_unsigned_sat;
      issue("R4 sub low", {8{16'h0000}}, {8{16'h0001}}, 2'd1, 1'b0, 1'b1, 3'd1, 1'b0);
      chk("R4 floor zero", result, '0);
      issue("R4 add high", {8{16'hFFFF}}, {8{16'h0001}}, 2'd1, 1'b0, 1'b1, 3'd0, 1'b0);
      chk("R4 all ones", result, {8{16'hFFFF}});
   endtask

   task automatic t_minmax;
      logic [127:0] a = 128'h80000000_00000005_FFFFFFFF_7FFFFFFF;
      logic [127:0] b = 128'h00000001_00000009_00000000_80000000;
      issue("R5 min signed", a, b, 2'd2, 1'b1, 1'b1, 3'd2, 1'b0);
      issue("R5 min unsigned", a, b, 2'd2, 1'b0, 1'b1, 3'd2, 1'b0);
      issue("R5 max signed 8b", a, b, 2'd0, 1'b1, 1'b0, 3'd3, 1'b0);
      issue("R5 max unsigned 16b", a, b, 2'd1, 1'b0, 1'b1, 3'd3, 1'b0);
   endtask

   task automatic t_avg;
      issue("R6 avg u8 top", {16{8'hFF}}, {16{8'hFF}}, 2'd0, 1'b0, 1'b1, 3'd4, 1'b0);
      chk("R6 avg no overflow", result, {16{8'hFF}});
      issue("R6 avg s16", {4{16'h8000, 16'h7FFF}}, {4{16'h8000, 16'hFFFE}}, 2'd1, 1'b1, 1'b1, 3'd4, 1'b0);
      issue("R6 avg round", {4{32'h00000003}}, {4{32'h00000004}}, 2'd2, 1'b0, 1'b0, 3'd4, 1'b0);
      chk("R6 round up", result, {4{32'h00000004}});
   endtask

   task automatic t_unused_op;
      issue("R7 op5", {16{8'h7F}}, {16{8'h7F}}, 2'd0, 1'b1, 1'b1, 3'd5, 1'b0);
      issue("R7 op7", {16{8'hFF}}, {16{8'h01}}, 2'd2, 1'b0, 1'b1, 3'd7, 1'b0);
      chk("R7 flag untouched", 128'(sat_flag), '0);
   endtask

   task automatic t_hold;
      logic [127:0] kept;
      issue("R9 setup", {16{8'h11}}, {16{8'h22}}, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0);
      kept = result;
      @(negedge clk);
      opnd_a = {16{8'h7F}}; opnd_b = {16{8'h7F}}; sat_mode = 1'b1; is_signed = 1'b1; opcode = 3'd0;
      @(negedge clk);
      chk("R9 held", result, kept);
      chk("R9 no valid", 128'(out_valid), '0);
      chk("R9 no flag", 128'(sat_flag), '0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_modulo();
      t_signed_sat();
      t_clear();
      t_unsigned_sat();
      @(negedge clk); sat_clr = 1'b1;
      @(negedge clk); sat_clr = 1'b0; exp_flag = 1'b0;
      t_minmax();
      t_avg();
      t_unused_op();
      t_hold();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 5000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule